// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block buffers nine-bit words between two unrelated clock domains. A producer writes on its own clock and a consumer reads on another. The storage holds 512 words. Words come out in the order they went in. The read data passes through an output register. A three-state output enable either drives that register onto the data bus or releases the bus.

Four active-low flags report the fill level. Two of them, empty and almost-empty, belong to the read side. The other two, full and almost-full, belong to the write side. Each flag is computed only from registers clocked by its own side's clock. The two almost flags compare the fill level against offsets that can be set to any single word. Both offsets are 7 after reset.

A dual-purpose pin is sampled while reset is held, and its level picks the mode:
- **Dual-enable mode** (pin high during reset): the pin is a second write qualifier.
- **Load mode** (pin low during reset): a write cycle with the pin low stores an offset instead of a data word.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high and after its release, `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and `dout` shows 0 with the output enabled.
- R2: In dual-enable mode, a word is stored on a `wr_clk` rising edge only when `wr_en_a_n` is 0 and `wr_en_b_ld` is 1. Any other combination stores nothing.
- R3: A word is removed on a `rd_clk` rising edge only when both `rd_en_a_n` and `rd_en_b_n` are 0 and the FIFO is not empty. The word then appears on `dout` after that edge, in write order.
- R4: `full_n` is 0 exactly when 512 words are held. Writes while full are discarded and do not overwrite stored data.
- R5: Reads while empty are discarded. `dout` keeps the last word read.
- R6: `aempty_n` is 0 when the word count is at most the almost-empty offset. `afull_n` is 0 when the count is at least 512 minus the almost-full offset. After reset both offsets are 7, so the thresholds are 7 and 505 words.
- R7: In load mode, a write cycle with `wr_en_b_ld` at 0 stores `din[8:0]` as an offset and does not enter the FIFO. These loads alternate: the almost-empty offset first, then the almost-full offset. A write cycle with `wr_en_b_ld` at 1 is a normal FIFO write.
- R8: `dout` is high-impedance while `out_en_n` is 1 and carries the output register while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| wr_en_a_n | input | 1 | Primary write enable, active low |
| wr_en_b_ld | input | 1 | Second write enable (high active) or offset-load control (low active), chosen at reset |
| din | input | 9 | Write data / offset value |
| rd_en_a_n | input | 1 | Read enable one, active low |
| rd_en_b_n | input | 1 | Read enable two, active low |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data, three-state |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| full_n | output | 1 | Full flag, active low, write clock |

## Verification
A pointer that slips shows up at the ports in two ways: words come out in the wrong order, or the FIFO holds a count that does not match the flags. The scoreboard catches a misordered word on the very read that returns it. A flag or offset error shows up within a few cycles of the other clock once the synchronizers settle. The bench therefore checks every flag after such a settle period, at counts one word on each side of a threshold. An overwrite while full would not show until the whole FIFO drains, so the bench drains it completely and requires the expected queue to end empty.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    localparam int unsigned DATA_W      = 9;
    localparam int unsigned ADDR_W      = 9;
    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned OFF_RESET   = 7;

    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_DUAL = 1'b1
    } wmode_e;

    typedef enum logic {
        SEL_AEMPTY = 1'b0,
        SEL_AFULL  = 1'b1
    } offsel_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES < 2) begin : g_single
            logic [W-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= RST_VAL;
                else     stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned DATA_W      = 9,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OFF_RESET   = 7
) (
    input  logic              wr_clk,
    input  logic              rst,
    input  logic              en_a_n,
    input  logic              en_b_ld,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W:0]   rgray_async,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] ae_off,
    output logic              full_n,
    output logic              afull_n
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    logic [PTR_W-1:0]  wbin_q, wgray_q, rgray_s, rbin_s, count, af_thr;
    logic [ADDR_W-1:0] af_off_q, ae_off_q;
    wmode_e            mode_q;
    offsel_e           sel_q;
    logic              is_full, push, load;

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
        .clk(wr_clk), .rst(rst), .d(rgray_async), .q(rgray_s)
    );

    assign rbin_s  = PTR_W'(gray2bin(32'(rgray_s)));
    assign count   = wbin_q - rbin_s;
    assign af_thr  = DEPTH_P - {1'b0, af_off_q};
    assign is_full = (count == DEPTH_P);

    assign push = !rst && !en_a_n && en_b_ld && !is_full;
    assign load = !rst && (mode_q == MODE_LOAD) && !en_a_n && !en_b_ld;

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            wbin_q   <= '0;
            wgray_q  <= '0;
            mode_q   <= wmode_e'(en_b_ld);
            sel_q    <= SEL_AEMPTY;
            ae_off_q <= ADDR_W'(OFF_RESET);
            af_off_q <= ADDR_W'(OFF_RESET);
        end else begin
            if (push) begin
                wbin_q  <= wbin_q + 1'b1;
                wgray_q <= PTR_W'(bin2gray(32'(wbin_q + 1'b1)));
            end
            if (load) begin
                if (sel_q == SEL_AEMPTY) ae_off_q <= din[ADDR_W-1:0];
                else                     af_off_q <= din[ADDR_W-1:0];
                sel_q <= (sel_q == SEL_AEMPTY) ? SEL_AFULL : SEL_AEMPTY;
            end
        end
    end

    assign mem_we    = push;
    assign mem_waddr = wbin_q[ADDR_W-1:0];
    assign mem_wdata = din;
    assign wgray     = wgray_q;
    assign ae_off    = ae_off_q;
    assign full_n    = !is_full;
    assign afull_n   = !(count >= af_thr);

    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (rst)
        !full_n |=> (wbin_q == $past(wbin_q)));

    assert_count_bound_R4: assert property (@(posedge wr_clk) disable iff (rst)
        count <= DEPTH_P);

    assert_afull_covers_full_R6: assert property (@(posedge wr_clk) disable iff (rst)
        !full_n |-> !afull_n);

    assert_load_not_stored_R7: assert property (@(posedge wr_clk) disable iff (rst)
        load |=> (wbin_q == $past(wbin_q)));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int unsigned DATA_W      = 9,
    parameter int unsigned ADDR_W      = 9,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned OFF_RESET   = 7
) (
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              en_a_n,
    input  logic              en_b_n,
    input  logic [ADDR_W:0]   wgray_async,
    input  logic [ADDR_W-1:0] ae_off_async,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] q,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  rbin_q, rgray_q, wgray_s, wbin_s, count;
    logic [ADDR_W-1:0] ae_off_s;
    logic [DATA_W-1:0] q_q;
    logic              is_empty, pop;

    dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(rd_clk), .rst(rst), .d(wgray_async), .q(wgray_s)
    );

    dcf_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES),
               .RST_VAL(ADDR_W'(OFF_RESET))) u_offsync (
        .clk(rd_clk), .rst(rst), .d(ae_off_async), .q(ae_off_s)
    );

    assign wbin_s   = PTR_W'(gray2bin(32'(wgray_s)));
    assign count    = wbin_s - rbin_q;
    assign is_empty = (count == '0);
    assign pop      = !rst && !en_a_n && !en_b_n && !is_empty;

    always_ff @(posedge rd_clk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            q_q     <= '0;
        end else if (pop) begin
            rbin_q  <= rbin_q + 1'b1;
            rgray_q <= PTR_W'(bin2gray(32'(rbin_q + 1'b1)));
            q_q     <= mem_rdata;
        end
    end

    assign mem_raddr = rbin_q[ADDR_W-1:0];
    assign rgray     = rgray_q;
    assign q         = q_q;
    assign empty_n   = !is_empty;
    assign aempty_n  = !(count <= {1'b0, ae_off_s});

    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (rst)
        !empty_n |=> ($stable(q) && rbin_q == $past(rbin_q)));

    assert_aempty_covers_empty_R6: assert property (@(posedge rd_clk) disable iff (rst)
        !empty_n |-> !aempty_n);

    assert_reset_state_R1: assert property (@(posedge rd_clk)
        rst |=> (q == '0 && !empty_n));

    assert_read_gated_R3: assert property (@(posedge rd_clk) disable iff (rst)
        (en_a_n || en_b_n) |=> $stable(q));
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcfifo_pkg::*;
#(
    parameter int unsigned DW    = dcfifo_pkg::DATA_W,
    parameter int unsigned AW    = dcfifo_pkg::ADDR_W,
    parameter int unsigned SYNC  = dcfifo_pkg::SYNC_STAGES,
    parameter int unsigned OFF_R = dcfifo_pkg::OFF_RESET
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          wr_en_a_n,
    input  logic          wr_en_b_ld,
    input  logic [DW-1:0] din,
    input  logic          rd_en_a_n,
    input  logic          rd_en_b_n,
    input  logic          out_en_n,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          aempty_n,
    output logic          afull_n,
    output logic          full_n
);
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr, ae_off;
    logic [DW-1:0] mem_wdata, mem_rdata, q;
    logic [AW:0]   wgray, rgray;

    dcf_wr_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC), .OFF_RESET(OFF_R)) u_wr (
        .wr_clk(wr_clk), .rst(rst), .en_a_n(wr_en_a_n), .en_b_ld(wr_en_b_ld),
        .din(din), .rgray_async(rgray), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .wgray(wgray), .ae_off(ae_off),
        .full_n(full_n), .afull_n(afull_n)
    );

    dcf_ram #(.DATA_W(DW), .ADDR_W(AW)) u_ram (
        .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    dcf_rd_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC), .OFF_RESET(OFF_R)) u_rd (
        .rd_clk(rd_clk), .rst(rst), .en_a_n(rd_en_a_n), .en_b_n(rd_en_b_n),
        .wgray_async(wgray), .ae_off_async(ae_off), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rgray(rgray), .q(q),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    assign dout = out_en_n ? 'z : q;
endmodule

// File: tb/dcfifo_pflag_test.sv
`timescale 1ns/1ps
module dcfifo_pflag_test;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD + 4;
    localparam int DEPTH       = 512;

    logic       wr_clk = 0, rd_clk = 0, rst = 1;
    logic       wr_en_a_n = 1, wr_en_b_ld = 1, rd_en_a_n = 1, rd_en_b_n = 1, out_en_n = 0;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       empty_n, aempty_n, afull_n, full_n;

    int checks = 0, errors = 0, model_cnt = 0, wseq = 1;
    bit pop_seen = 0;
    logic [8:0] exp_q[$];
    logic [8:0] last_read = '0;

    always #(CLK_PERIOD/2)  wr_clk = ~wr_clk;
    always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

    dcfifo_pflag uut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en_a_n(wr_en_a_n),
        .wr_en_b_ld(wr_en_b_ld), .din(din), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
        .out_en_n(out_en_n), .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Scoreboard monitor: a read is due when both enables are low and the FIFO shows non-empty
    always @(posedge rd_clk) begin
        pop_seen = (!rd_en_a_n && !rd_en_b_n && empty_n === 1'b1 && !rst);
    end

    always @(negedge rd_clk) begin
        if (pop_seen) begin
            pop_seen = 0;
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected word", int'(dout), -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check(dout === e, "R3 read order", int'(dout), int'(e));
                last_read = e;
                model_cnt--;
            end
        end
    end

    task automatic do_reset(input logic mode_pin);
        @(negedge wr_clk);
        rst = 1; wr_en_b_ld = mode_pin; wr_en_a_n = 1;
        repeat (5) @(negedge rd_clk);
        @(negedge wr_clk);
        rst = 0; wr_en_b_ld = 1;
        exp_q.delete(); model_cnt = 0; last_read = '0;
        repeat (2) @(negedge rd_clk);
    endtask

    // Write cycles; en_b is the level on the second enable pin
    task automatic do_writes(input int n, input logic en_b, input bit stores);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en_a_n = 0; wr_en_b_ld = en_b; din = 9'(wseq);
            if (stores && model_cnt < DEPTH) begin
                exp_q.push_back(9'(wseq));
                model_cnt++;
            end
            wseq = (wseq + 37) % DEPTH;
        end
        @(negedge wr_clk);
        wr_en_a_n = 1; wr_en_b_ld = 1;
    endtask

    task automatic load_off(input int v);
        @(negedge wr_clk);
        wr_en_a_n = 0; wr_en_b_ld = 0; din = 9'(v);
        @(negedge wr_clk);
        wr_en_a_n = 1; wr_en_b_ld = 1;
    endtask

    task automatic do_reads(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            rd_en_a_n = 0; rd_en_b_n = 0;
        end
        @(negedge rd_clk);
        rd_en_a_n = 1; rd_en_b_n = 1;
        @(negedge rd_clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        summary();
        $finish;
    end

    initial begin
        // ---------- dual-enable mode ----------
        do_reset(1'b1);
        check(empty_n === 1'b0,  "R1 empty_n", int'(empty_n), 0);
        check(aempty_n === 1'b0, "R1 aempty_n", int'(aempty_n), 0);
        check(full_n === 1'b1,   "R1 full_n", int'(full_n), 1);
        check(afull_n === 1'b1,  "R1 afull_n", int'(afull_n), 1);
        check(dout === 9'd0,     "R1 dout", int'(dout), 0);

        out_en_n = 1; #1;
        check(dout === 9'bz, "R8 dout released", int'(dout), -1);
        out_en_n = 0; #1;
        check(dout === 9'd0, "R8 dout driven", int'(dout), 0);

        // R2: second enable low is not a write
        do_writes(3, 1'b0, 0);
        settle();
        check(empty_n === 1'b0, "R2 write gated by second enable", int'(empty_n), 0);

        do_writes(3, 1'b1, 1);
        settle();
        check(empty_n === 1'b1,  "R2 write accepted", int'(empty_n), 1);
        check(aempty_n === 1'b0, "R6 3 words almost empty", int'(aempty_n), 0);

        // R3: only one read enable low does not read
        @(negedge rd_clk); rd_en_a_n = 0;
        repeat (3) @(negedge rd_clk);
        rd_en_a_n = 1; @(negedge rd_clk);
        check(dout === 9'd0, "R3 single enable no read", int'(dout), 0);

        do_reads(3);
        settle();
        check(empty_n === 1'b0, "R3 drained to empty", int'(empty_n), 0);

        // R5: reads while empty
        do_reads(2);
        check(dout === last_read, "R5 dout held when empty", int'(dout), int'(last_read));

        // R6 almost-empty boundary with default offset 7
        do_writes(7, 1'b1, 1);
        settle();
        check(aempty_n === 1'b0, "R6 7 words", int'(aempty_n), 0);
        do_writes(1, 1'b1, 1);
        settle();
        check(aempty_n === 1'b1, "R6 8 words", int'(aempty_n), 1);

        // R6 almost-full boundary: 505 words
        do_writes(496, 1'b1, 1);
        settle();
        check(afull_n === 1'b1, "R6 504 words", int'(afull_n), 1);
        do_writes(1, 1'b1, 1);
        settle();
        check(afull_n === 1'b0, "R6 505 words", int'(afull_n), 0);
        check(full_n === 1'b1,  "R4 not full at 505", int'(full_n), 1);

        // R4: fill and overfill
        do_writes(7, 1'b1, 1);
        settle();
        check(full_n === 1'b0, "R4 full at 512", int'(full_n), 0);
        do_writes(3, 1'b1, 1);
        settle();
        check(full_n === 1'b0, "R4 still full", int'(full_n), 0);
        do_reads(DEPTH + 2);
        settle();
        check(full_n === 1'b1,  "R4 full cleared", int'(full_n), 1);
        check(empty_n === 1'b0, "R4 drained", int'(empty_n), 0);
        check(exp_q.size() == 0, "R4 all words returned", exp_q.size(), 0);

        // ---------- load mode ----------
        do_reset(1'b0);
        load_off(2);
        load_off(3);
        settle();
        check(empty_n === 1'b0, "R7 loads not stored", int'(empty_n), 0);
        do_writes(3, 1'b1, 1);
        settle();
        check(aempty_n === 1'b1, "R7 ae offset 2 at 3 words", int'(aempty_n), 1);
        do_reads(1);
        settle();
        check(aempty_n === 1'b0, "R7 ae offset 2 at 2 words", int'(aempty_n), 0);
        do_reads(2);
        do_writes(508, 1'b1, 1);
        settle();
        check(afull_n === 1'b1, "R7 af offset 3 at 508", int'(afull_n), 1);
        do_writes(1, 1'b1, 1);
        settle();
        check(afull_n === 1'b0, "R7 af offset 3 at 509", int'(afull_n), 0);
        do_reads(510);
        settle();
        check(exp_q.size() == 0, "R7 all words returned", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule